// File: doc/BRIEF.md
# Coalescing Store Buffer with Read-Miss Bypass

This block sits between a write-through, no-write-allocate data cache and the next level of memory. Each store from the cache is placed in a block-aligned entry. The entry keeps one data word per word slot and one valid bit per byte. A store to a block that already has an entry waiting in the buffer is folded into that entry. Because the store does not take a new slot, the buffer fills up less often and the cache stalls on a full buffer less often.

Entries leave in the order they were allocated. Each entry leaves as one memory write transaction that carries byte enables for only the bytes that were stored. A read miss may reach memory before the writes that are still queued. Before it does, its block address is compared with every entry in the buffer, including the one in flight, and with any store arriving in the same cycle. If there is a match, the read is held back, and the drain carries on in order until no matching entry remains. The read is then granted.

Store addresses are word addresses: the upper bits give the block and the low bits give the word slot. Read-miss addresses are block addresses.

Top module: `merge_wbuf`

## Requirements
- R1: After reset the buffer is empty. `full` and `mem_wr_valid` are low, `st_ready` is high, and `rd_gnt` equals `rd_req` for any read address.
- R2: A store's block is `st_addr[ADDR_W-1:WSEL_W]` and its word slot is `st_addr[WSEL_W-1:0]`. Bit k of `st_be` enables byte k of `st_data`. That byte lands at bit `w*DATA_W + 8k` of the line in slot w and is marked by bit `w*(DATA_W/8) + k` of the entry's byte mask.
- R3: A store to a block that has an entry not yet in flight is merged into that entry without taking a new one. Only its enabled bytes are overwritten, and the byte mask becomes the union of the old and new masks.
- R4: A store matching no mergeable entry takes a new entry with a clear mask. When all DEPTH entries are in use and there is no merge target, `st_ready` is low. `full` is high exactly when all entries are in use.
- R5: Entries drain oldest allocation first, one entry per transaction. `mem_wr_addr`, `mem_wr_data` and `mem_wr_be` carry the entry's block, line and byte mask.
- R6: Once an entry is launched, `mem_wr_valid` stays high with a stable payload until `mem_wr_ready`. A later store to the same block opens a new entry.
- R7: `rd_gnt` is high in the same cycle that `rd_req` is high, provided that `rd_addr` matches no buffered entry (in flight or not) and no store arriving that cycle.
- R8: A conflicting read is stalled, with `rd_gnt` low, until every matching entry has retired. The drain keeps going while the read waits.
- R9: In a cycle where `rd_gnt` is high, no new write is launched, so `mem_wr_valid` does not rise in the next cycle.
- R10: An idle, non-empty buffer with no granted read raises `mem_wr_valid` in the next cycle. An entry retires at the clock edge where `mem_wr_valid` and `mem_wr_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Store accepted this cycle when high |
| st_addr | input | ADDR_W | Store word address (block and slot) |
| st_data | input | DATA_W | Store data word |
| st_be | input | DATA_W/8 | Store byte enables |
| rd_req | input | 1 | Read miss wants to go to memory |
| rd_addr | input | ADDR_W-WSEL_W | Read miss block address |
| rd_gnt | output | 1 | Read miss may proceed this cycle |
| mem_wr_valid | output | 1 | Write transaction offered to memory |
| mem_wr_ready | input | 1 | Memory accepts the write |
| mem_wr_addr | output | ADDR_W-WSEL_W | Block address of the write |
| mem_wr_data | output | WORDS*DATA_W | Line data of the write |
| mem_wr_be | output | WORDS*DATA_W/8 | Byte enables of the write |
| full | output | 1 | All entries in use |

## Verification
The assertions check four things on every cycle:
- The write payload holds steady while memory back-pressures it.
- At most one entry is a merge target.
- The occupancy count agrees with the valid bits of the entries.
- A granted read blocks a drain launch.

Only the bench's scenarios can show the rest:
- Merged bytes land in the right lanes.
- Blocks drain in allocation order.
- A conflicting read is held back until exactly the right retirement.
- A full buffer turns away a store while still accepting one that merges.

The bench checks these with a behavioural queue model that is compared with the outputs on every cycle, under random stores, reads and memory stalls.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
    // Drain engine state: idle, or one entry offered to memory
    typedef enum logic {DRN_IDLE = 1'b0, DRN_SEND = 1'b1} drn_state_e;
endpackage

// File: rtl/wbuf_match.sv
// wbuf_match: compares the incoming store block and the read-miss block
// against every buffered entry.
// Assumes: at most one valid entry that is not in flight holds a given
// block; the in-flight entry is always the head.
module wbuf_match #(
    parameter int DEPTH = 4,
    parameter int BLK_W = 28,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]       ent_vld,
    input  logic [DEPTH*BLK_W-1:0] ent_blk,
    input  logic [PTR_W-1:0]       head_idx,
    input  logic                   head_busy,
    input  logic [BLK_W-1:0]       st_blk,
    input  logic [BLK_W-1:0]       rd_blk,
    output logic [DEPTH-1:0]       st_hit,
    output logic                   rd_hit
);
    logic [DEPTH-1:0] rd_hit_vec;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        logic in_flight;
        // entry i is the one currently offered to memory
        assign in_flight     = head_busy && (head_idx == PTR_W'(i));
        // merge target: valid, same block, not in flight
        assign st_hit[i]     = ent_vld[i] && !in_flight &&
                               (ent_blk[i*BLK_W +: BLK_W] == st_blk);
        // any valid entry of the same block blocks a read
        assign rd_hit_vec[i] = ent_vld[i] &&
                               (ent_blk[i*BLK_W +: BLK_W] == rd_blk);
    end

    assign rd_hit = |rd_hit_vec;
endmodule

// File: rtl/wbuf_ctrl.sv
// wbuf_ctrl: allocation and drain pointers, occupancy and the drain engine.
// Assumes: push is never raised when count == DEPTH; hold_launch is high
// in cycles where a read miss is granted.
module wbuf_ctrl
    import wbuf_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             hold_launch,
    input  logic             mem_ready,
    output logic [PTR_W-1:0] head,
    output logic [PTR_W-1:0] tail,
    output logic [CNT_W-1:0] count,
    output logic             busy,
    output logic             pop
);
    drn_state_e state;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign busy = (state == DRN_SEND);
    assign pop  = busy && mem_ready;

    // pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (pop)  head <= nxt(head);
            if (push) tail <= nxt(tail);
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end

    // drain engine: launch the head when idle unless a read goes first
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= DRN_IDLE;
        end else begin
            case (state)
                DRN_IDLE: if (count != '0 && !hold_launch) state <= DRN_SEND;
                DRN_SEND: if (mem_ready) state <= DRN_IDLE;
                default:  state <= DRN_IDLE;
            endcase
        end
    end

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count < CNT_W'(DEPTH)));

    p_hold_offer_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !mem_ready |=> busy);
endmodule

// File: rtl/merge_wbuf.sv
// merge_wbuf: coalescing write buffer between a write-through cache and
// memory.
//  - Stores merge by block into entries that are not in flight.
//  - Entries drain in allocation order.
//  - Read misses bypass queued writes unless their block is buffered.
// Assumes: WORDS and DATA_W/8 are powers of two, WORDS >= 2.
module merge_wbuf #(
    parameter int ADDR_W = 30,
    parameter int DATA_W = 32,
    parameter int WORDS  = 4,
    parameter int DEPTH  = 4,
    localparam int BYTES  = DATA_W / 8,
    localparam int BO_W   = $clog2(BYTES),
    localparam int WSEL_W = $clog2(WORDS),
    localparam int BLK_W  = ADDR_W - WSEL_W,
    localparam int LINE_W = WORDS * DATA_W,
    localparam int LBE_W  = WORDS * BYTES,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    output logic              st_ready,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    input  logic [BYTES-1:0]  st_be,
    input  logic              rd_req,
    input  logic [BLK_W-1:0]  rd_addr,
    output logic              rd_gnt,
    output logic              mem_wr_valid,
    input  logic              mem_wr_ready,
    output logic [BLK_W-1:0]  mem_wr_addr,
    output logic [LINE_W-1:0] mem_wr_data,
    output logic [LBE_W-1:0]  mem_wr_be,
    output logic              full
);
    logic [BLK_W-1:0]       blk_q  [DEPTH];
    logic [LINE_W-1:0]      data_q [DEPTH];
    logic [LBE_W-1:0]       be_q   [DEPTH];
    logic [DEPTH-1:0]       vld_q;
    logic [DEPTH*BLK_W-1:0] blk_flat;

    logic [PTR_W-1:0]  head, tail;
    logic [CNT_W-1:0]  count;
    logic              busy, pop, push, st_fire, merge_hit, rd_hit;
    logic [DEPTH-1:0]  st_hit;
    logic [BLK_W-1:0]  st_blk;
    logic [WSEL_W-1:0] st_slot;
    logic [LBE_W-1:0]  wmask;
    logic [LINE_W-1:0] wbits, wdata;

    assign st_blk  = st_addr[ADDR_W-1:WSEL_W];
    assign st_slot = st_addr[WSEL_W-1:0];
    assign wdata   = {WORDS{st_data}};
    assign wmask   = LBE_W'(st_be) << {st_slot, {BO_W{1'b0}}};

    // expand the byte mask of the incoming store to a bit mask
    always_comb begin
        for (int b = 0; b < LBE_W; b++) wbits[b*8 +: 8] = {8{wmask[b]}};
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_flat
        assign blk_flat[i*BLK_W +: BLK_W] = blk_q[i];
    end

    wbuf_match #(.DEPTH(DEPTH), .BLK_W(BLK_W)) u_match (
        .ent_vld(vld_q), .ent_blk(blk_flat), .head_idx(head),
        .head_busy(busy), .st_blk(st_blk), .rd_blk(rd_addr),
        .st_hit(st_hit), .rd_hit(rd_hit)
    );

    assign full      = (count == CNT_W'(DEPTH));
    assign merge_hit = |st_hit;
    assign st_ready  = merge_hit || !full;
    assign st_fire   = st_valid && st_ready;
    assign push      = st_fire && !merge_hit;
    assign rd_gnt    = rd_req && !rd_hit && !(st_valid && st_blk == rd_addr);

    wbuf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .push(push), .hold_launch(rd_gnt),
        .mem_ready(mem_wr_ready), .head(head), .tail(tail), .count(count),
        .busy(busy), .pop(pop)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic sel_new, sel_merge;
        assign sel_new   = push && (tail == PTR_W'(i));
        assign sel_merge = st_fire && st_hit[i];
        // entry storage: clear on retire, allocate or merge enabled bytes
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[i]  <= 1'b0;
                blk_q[i]  <= '0;
                data_q[i] <= '0;
                be_q[i]   <= '0;
            end else begin
                if (pop && head == PTR_W'(i)) vld_q[i] <= 1'b0;
                if (sel_new || sel_merge) begin
                    vld_q[i]  <= 1'b1;
                    blk_q[i]  <= st_blk;
                    data_q[i] <= (data_q[i] & ~wbits) | (wdata & wbits);
                    be_q[i]   <= (sel_new ? '0 : be_q[i]) | wmask;
                end
            end
        end
    end

    assign mem_wr_valid = busy;
    assign mem_wr_addr  = blk_q[head];
    assign mem_wr_data  = data_q[head];
    assign mem_wr_be    = be_q[head];

    p_payload_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid && !mem_wr_ready |=> mem_wr_valid && $stable(mem_wr_addr)
        && $stable(mem_wr_data) && $stable(mem_wr_be));

    p_one_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(st_hit));

    p_count_matches_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(vld_q) == int'(count));

    p_read_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_gnt && !mem_wr_valid |=> !mem_wr_valid);
endmodule

// File: tb/merge_wbuf_tb.sv
module merge_wbuf_tb;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [27:0]  blk;
        logic [127:0] data;
        logic [15:0]  be;
        bit           busy;
    } ent_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic st_valid = 0, rd_req = 0, mem_wr_ready = 0;
    logic [29:0] st_addr = '0;
    logic [31:0] st_data = '0;
    logic [3:0]  st_be = '0;
    logic [27:0] rd_addr = '0;
    logic st_ready, rd_gnt, mem_wr_valid, full;
    logic [27:0]  mem_wr_addr;
    logic [127:0] mem_wr_data;
    logic [15:0]  mem_wr_be;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    ent_t q[$];
    logic e_ready, e_full, e_gnt, e_valid;
    int   e_mi;

    always #(CLK_PERIOD/2) clk = ~clk;

    merge_wbuf u_dut (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
        .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_gnt(rd_gnt),
        .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
        .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .mem_wr_be(mem_wr_be), .full(full)
    );

    task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
        end
    endtask

    function automatic logic [127:0] bitmask(logic [15:0] be);
        logic [127:0] m;
        for (int b = 0; b < 16; b++) m[b*8 +: 8] = {8{be[b]}};
        return m;
    endfunction

    // expected combinational outputs from the model state and current inputs
    task automatic calc_exp();
        logic [27:0] sb = st_addr[29:2];
        e_mi = -1;
        for (int i = 0; i < q.size(); i++)
            if (q[i].blk == sb && !q[i].busy) e_mi = i;
        e_full  = (q.size() == 4);
        e_ready = (e_mi >= 0) || !e_full;
        e_gnt   = rd_req && !(st_valid && sb == rd_addr);
        for (int i = 0; i < q.size(); i++) if (q[i].blk == rd_addr) e_gnt = 0;
        e_valid = (q.size() > 0) && q[0].busy;
    endtask

    task automatic compare_all();
        calc_exp();
        chk("R4 st_ready", 128'(st_ready), 128'(e_ready));
        chk("R4 full", 128'(full), 128'(e_full));
        chk("R7 rd_gnt", 128'(rd_gnt), 128'(e_gnt));
        chk("R10 mem_wr_valid", 128'(mem_wr_valid), 128'(e_valid));
        if (e_valid) begin
            chk("R5 mem_wr_addr", 128'(mem_wr_addr), 128'(q[0].blk));
            chk("R2 mem_wr_be", 128'(mem_wr_be), 128'(q[0].be));
            chk("R3 mem_wr_data", mem_wr_data & bitmask(q[0].be),
                q[0].data & bitmask(q[0].be));
        end
    endtask

    // apply one clock edge to the model using pre-edge values
    task automatic model_edge();
        logic [15:0]  m;
        logic [127:0] bm, wd;
        bit pop, launch, acc;
        calc_exp();
        m      = 16'(st_be) << (st_addr[1:0] * 4);
        bm     = bitmask(m);
        wd     = {4{st_data}};
        acc    = st_valid && e_ready;
        pop    = (q.size() > 0) && q[0].busy && mem_wr_ready;
        launch = (q.size() > 0) && !q[0].busy && !e_gnt;
        if (acc && e_mi >= 0) begin
            q[e_mi].data = (q[e_mi].data & ~bm) | (wd & bm);
            q[e_mi].be   = q[e_mi].be | m;
        end
        if (launch) q[0].busy = 1;
        if (pop) void'(q.pop_front());
        if (acc && e_mi < 0) begin
            ent_t n;
            n.blk = st_addr[29:2]; n.data = wd & bm; n.be = m; n.busy = 0;
            q.push_back(n);
        end
    endtask

    task automatic step();
        #1 compare_all();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic store(logic [27:0] b, logic [1:0] w, logic [31:0] d, logic [3:0] e);
        st_valid = 1; st_addr = {b, w}; st_data = d; st_be = e;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state, unmatched read granted at once
        rd_req = 1; rd_addr = 28'h5;
        #1;
        chk("R1 st_ready", 128'(st_ready), 128'(1));
        chk("R1 full", 128'(full), 128'(0));
        chk("R1 mem_wr_valid", 128'(mem_wr_valid), 128'(0));
        chk("R1 rd_gnt", 128'(rd_gnt), 128'(1));
        step();
        rd_req = 0;

        // R3 / R6: merge before launch, new entry after launch
        mem_wr_ready = 0;
        store(28'h10, 2'd1, 32'h11223344, 4'hF); step();
        store(28'h10, 2'd1, 32'hAABBCCDD, 4'h3); step();
        store(28'h10, 2'd2, 32'h00000055, 4'h1);
        #1;
        chk("R3 merged be", 128'(mem_wr_be), 128'(16'h00F0));
        chk("R3 merged data", 128'(mem_wr_data[63:32]), 128'(32'h1122CCDD));
        step();
        st_valid = 0;
        step(); step();
        chk("R6 still offered", 128'(mem_wr_valid), 128'(1));
        mem_wr_ready = 1; step();
        mem_wr_ready = 0;
        for (int k = 0; k < 4 && !mem_wr_valid; k++) step();
        #1;
        chk("R6 second entry be", 128'(mem_wr_be), 128'(16'h0100));
        chk("R6 second entry blk", 128'(mem_wr_addr), 128'(28'h10));
        mem_wr_ready = 1; step(); step();

        // R8: conflicting read waits until the matching entry retires
        mem_wr_ready = 0;
        store(28'h20, 2'd0, 32'hCAFEF00D, 4'hF); step();
        st_valid = 0; step();
        rd_req = 1; rd_addr = 28'h20;
        #1 chk("R8 conflict stalls", 128'(rd_gnt), 128'(0));
        step(); step();
        #1 chk("R8 still stalled", 128'(rd_gnt), 128'(0));
        mem_wr_ready = 1; step();
        #1 chk("R8 granted after retire", 128'(rd_gnt), 128'(1));
        step();
        rd_req = 0;

        // R9: granted reads hold back the drain launch
        store(28'h30, 2'd3, 32'h01020304, 4'hF);
        rd_req = 1; rd_addr = 28'h31;
        step();
        st_valid = 0; step(); step();
        #1 chk("R9 no launch under read", 128'(mem_wr_valid), 128'(0));
        rd_req = 0; step();
        #1 chk("R9 launch after read", 128'(mem_wr_valid), 128'(1));
        step();

        // R4 / R5: fill, refuse, merge while full, then ordered drain
        mem_wr_ready = 0;
        for (int k = 0; k < 4; k++) begin
            store(28'h40 + 28'(k), 2'(k), 32'h1000 + 32'(k), 4'hF); step();
        end
        store(28'h50, 2'd0, 32'h0, 4'hF);
        #1;
        chk("R4 refused when full", 128'(st_ready), 128'(0));
        chk("R4 full flag", 128'(full), 128'(1));
        store(28'h42, 2'd0, 32'h77, 4'h1);
        #1 chk("R4 merge accepted while full", 128'(st_ready), 128'(1));
        step();
        st_valid = 0;
        mem_wr_ready = 1;
        for (int k = 0; k < 4; k++) begin
            for (int t = 0; t < 4 && !mem_wr_valid; t++) step();
            #1 chk("R5 drain order", 128'(mem_wr_addr), 128'(28'h40 + 28'(k)));
            step();
        end

        // random mix on a small block set
        for (int c = 0; c < 3000; c++) begin
            st_valid = ($urandom % 3) != 0;
            st_addr  = {28'h60 + 28'($urandom % 5), 2'($urandom)};
            st_data  = $urandom;
            st_be    = 4'($urandom);
            rd_req   = ($urandom % 3) == 0;
            rd_addr  = 28'h60 + 28'($urandom % 7);
            mem_wr_ready = ($urandom % 4) != 0;
            step();
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule